// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Capture Unit

This block is the interrupt engine of a general-purpose I/O expander port. It takes the raw pin levels, passes them through a synchronizer, applies optional per-pin inversion, and watches every pin that is an enabled input. Each pin can watch for either of two conditions. The first is any change from the value it had one clock earlier. The second is a level that differs from a programmed reference bit.

Pins are grouped into banks of equal width. When a bank's first qualifying event arrives, the bank latches a one-hot flag naming the pin that caused it. In the same edge it freezes a snapshot of that bank's corrected pin values. Both stay unchanged until software performs the clearing read. Depending on a configuration bit, that read is either a read of the live port value or a read of the snapshot. Each bank drives an interrupt pin. Its active level and its drive style can be set, and the banks can be made to share one combined request on every pin.

The register bus, the register storage and the pad cells sit outside. They hand this unit the register contents as level inputs and the read strobes as single-cycle pulses.

Top module: `gpioic_top`

## Requirements
- R1: After reset every flag bit and every snapshot bit is 0, and every interrupt pin rests at its inactive level.
- R2: In compare-with-previous mode (mode bit 0), a pin change sets the bank flag on the third rising clock edge after the change reaches the pin input, and not before. Two synchronizer stages plus the flag register account for the three edges.
- R3: In compare-with-reference mode (mode bit 1), a pin requests an interrupt on every clock edge where its corrected value differs from its reference bit. A change that brings the pin to its reference value raises nothing.
- R4: A pending bank flag holds exactly one set bit. Events on other pins of that bank do not add bits until the flag is cleared. When several pins qualify on the same edge, the lowest-numbered pin wins.
- R5: The snapshot of a bank is the corrected value of that bank's pins on the edge its flag is set. It stays frozen while the flag is pending and is not touched when the other bank fires.
- R6: With the clear-select input at 0, a port-read strobe of a bank clears that bank's flag on the next edge, and a snapshot-read strobe has no effect. The snapshot keeps its value after the clear.
- R7: With the clear-select input at 1, a snapshot-read strobe clears the bank's flag, and a port-read strobe has no effect.
- R8: If a compare-with-reference mismatch still holds when the flag is cleared, the flag is set again on the very next clock edge.
- R9: A pin can set a flag only when its enable bit is 1 and its direction bit is 1 (input).
- R10: The inversion mask is XORed onto the synchronized pins before comparison, before capture, and before the port value output.
- R11: The active-level input selects the active level of the interrupt pins (1 = active high). Each pin shows the active level while its request is set and the opposite level otherwise.
- R12: In open-drain mode the pin output-enable is 1 only while the request is set. In push-pull mode it is always 1. The pin value follows R11 in both modes.
- R13: With the mirror input at 1, every interrupt pin carries the OR of all banks' requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NUM_BANKS*PINS_PER_BANK | Raw pin levels, asynchronous |
| dir_is_in | input | NUM_BANKS*PINS_PER_BANK | Direction per pin, 1 = input |
| inv_mask | input | NUM_BANKS*PINS_PER_BANK | Per-pin input inversion |
| watch_en | input | NUM_BANKS*PINS_PER_BANK | Per-pin interrupt enable |
| ref_val | input | NUM_BANKS*PINS_PER_BANK | Reference levels for compare-with-reference mode |
| ref_mode | input | NUM_BANKS*PINS_PER_BANK | 1 = compare with reference, 0 = compare with previous |
| clr_on_snap | input | 1 | 1 = snapshot read clears, 0 = port read clears |
| act_high | input | 1 | Interrupt active level, 1 = high |
| open_drain | input | 1 | Interrupt pin drive style, 1 = open drain |
| mirror_en | input | 1 | Combine all bank requests on every pin |
| rd_port_stb | input | NUM_BANKS | Per-bank port-read pulse |
| rd_snap_stb | input | NUM_BANKS | Per-bank snapshot-read pulse |
| port_val | output | NUM_BANKS*PINS_PER_BANK | Synchronized, inverted pin values |
| flag_q | output | NUM_BANKS*PINS_PER_BANK | One-hot flag per bank |
| snap_q | output | NUM_BANKS*PINS_PER_BANK | Captured port per bank |
| irq_pin | output | NUM_BANKS | Interrupt pin value |
| irq_oe | output | NUM_BANKS | Interrupt pin output enable |

## Verification
The bench builds the unit with eight pins per bank and two banks, the default values. Two banks are needed to reach the cases that matter most here: one bank's snapshot staying frozen while the other fires, the per-bank clearing strobes, and mirroring, where a request from one bank must appear on the other bank's pin. Eight pins per bank leave room to make several pins in the same bank qualify at once, on the same edge or on later edges. That exercises the single-flag and lowest-index rules.

// File: rtl/gpioic_pkg.sv
package gpioic_pkg;

  typedef struct packed {
    logic clr_on_snap;
    logic act_high;
    logic open_drain;
    logic mirror;
  } irq_cfg_t;

  // Per-pin trigger condition: reference compare or change compare.
  function automatic logic pin_trig(input logic use_ref, input logic ref_bit,
                                    input logic now_bit, input logic prev_bit);
    return use_ref ? (now_bit != ref_bit) : (now_bit != prev_bit);
  endfunction

  // Level driven on an interrupt pin for a given request state.
  function automatic logic pin_level(input logic req, input logic act_hi);
    return req ? act_hi : ~act_hi;
  endfunction

endpackage

// File: rtl/gpioic_sync.sv
module gpioic_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpioic_bank.sv
module gpioic_bank
  import gpioic_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_now,
  input  logic [PINS-1:0] watch_en,
  input  logic [PINS-1:0] dir_is_in,
  input  logic [PINS-1:0] ref_mode,
  input  logic [PINS-1:0] ref_val,
  input  logic            clr_stb,
  output logic [PINS-1:0] flag_q,
  output logic [PINS-1:0] snap_q,
  output logic            bank_req,
  output logic [PINS-1:0] hit_vec,
  output logic            fire_evt
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] trig_vec;
  logic            pending;

  function automatic logic [PINS-1:0] first_hit(input logic [PINS-1:0] v);
    logic [PINS-1:0] r;
    r = '0;
    for (int i = PINS - 1; i >= 0; i--) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    assign trig_vec[p] = pin_trig(ref_mode[p], ref_val[p], pin_now[p], prev_q[p]);
  end

  assign hit_vec  = trig_vec & watch_en & dir_is_in;
  assign pending  = |flag_q;
  assign fire_evt = !pending && !clr_stb && (|hit_vec);
  assign bank_req = pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      snap_q <= '0;
    end else begin
      prev_q <= pin_now;
      if (clr_stb) begin
        flag_q <= '0;
      end else if (fire_evt) begin
        flag_q <= first_hit(hit_vec);
        snap_q <= pin_now;
      end
    end
  end

  assert_flag_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_q));

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr_stb) |=> (flag_q == $past(flag_q)));

  assert_snap_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr_stb) |=> $stable(snap_q));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (flag_q == '0));

  assert_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !clr_stb && (hit_vec != '0)) |=> (flag_q != '0));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q != '0) && ($past(flag_q) == '0))
      |-> ((flag_q & ~$past(watch_en & dir_is_in)) == '0));
endmodule

// File: rtl/gpioic_irq_drive.sv
module gpioic_irq_drive
  import gpioic_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic [NUM_BANKS-1:0] bank_req,
  input  irq_cfg_t             cfg,
  output logic [NUM_BANKS-1:0] eff_req,
  output logic [NUM_BANKS-1:0] irq_pin,
  output logic [NUM_BANKS-1:0] irq_oe
);
  logic any_req;
  assign any_req = |bank_req;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_drv
    assign eff_req[b] = cfg.mirror ? any_req : bank_req[b];
    assign irq_pin[b] = pin_level(eff_req[b], cfg.act_high);
    assign irq_oe[b]  = cfg.open_drain ? eff_req[b] : 1'b1;
  end
endmodule

// File: rtl/gpioic_top.sv
module gpioic_top
  import gpioic_pkg::*;
#(
  parameter int PINS_PER_BANK = 8,
  parameter int NUM_BANKS     = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_raw,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] dir_is_in,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] inv_mask,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] watch_en,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] ref_val,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] ref_mode,
  input  logic                               clr_on_snap,
  input  logic                               act_high,
  input  logic                               open_drain,
  input  logic                               mirror_en,
  input  logic [NUM_BANKS-1:0]               rd_port_stb,
  input  logic [NUM_BANKS-1:0]               rd_snap_stb,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] port_val,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] flag_q,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] snap_q,
  output logic [NUM_BANKS-1:0]               irq_pin,
  output logic [NUM_BANKS-1:0]               irq_oe
);
  localparam int W = NUM_BANKS * PINS_PER_BANK;

  irq_cfg_t             cfg;
  logic [W-1:0]         pin_sync;
  logic [W-1:0]         pin_corr;
  logic [W-1:0]         hit_all;
  logic [NUM_BANKS-1:0] bank_req;
  logic [NUM_BANKS-1:0] bank_clr;
  logic [NUM_BANKS-1:0] bank_fire;
  logic [NUM_BANKS-1:0] eff_req;

  assign cfg.clr_on_snap = clr_on_snap;
  assign cfg.act_high    = act_high;
  assign cfg.open_drain  = open_drain;
  assign cfg.mirror      = mirror_en;

  gpioic_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_raw),
    .d_sync  (pin_sync)
  );

  assign pin_corr = pin_sync ^ inv_mask;
  assign port_val = pin_corr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * PINS_PER_BANK;
    assign bank_clr[b] = cfg.clr_on_snap ? rd_snap_stb[b] : rd_port_stb[b];

    gpioic_bank #(.PINS(PINS_PER_BANK)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_now   (pin_corr[LO +: PINS_PER_BANK]),
      .watch_en  (watch_en[LO +: PINS_PER_BANK]),
      .dir_is_in (dir_is_in[LO +: PINS_PER_BANK]),
      .ref_mode  (ref_mode[LO +: PINS_PER_BANK]),
      .ref_val   (ref_val[LO +: PINS_PER_BANK]),
      .clr_stb   (bank_clr[b]),
      .flag_q    (flag_q[LO +: PINS_PER_BANK]),
      .snap_q    (snap_q[LO +: PINS_PER_BANK]),
      .bank_req  (bank_req[b]),
      .hit_vec   (hit_all[LO +: PINS_PER_BANK]),
      .fire_evt  (bank_fire[b])
    );
  end

  gpioic_irq_drive #(.NUM_BANKS(NUM_BANKS)) u_drive (
    .bank_req (bank_req),
    .cfg      (cfg),
    .eff_req  (eff_req),
    .irq_pin  (irq_pin),
    .irq_oe   (irq_oe)
  );

  assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> (irq_pin == {NUM_BANKS{~act_high}}));

  assert_od_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (open_drain && flag_q == '0) |-> (irq_oe == '0));

  assert_mirror_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_en && (flag_q != '0)) |-> (irq_pin == {NUM_BANKS{act_high}}));

  assert_fire_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_fire != '0) |=> (flag_q != '0));
endmodule

// File: tb/tb_gpioic_top.sv
module tb_gpioic_top;
  localparam int PPB = 8;
  localparam int NB  = 2;
  localparam int W   = PPB * NB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  pin_raw, dir_is_in, inv_mask, watch_en, ref_val, ref_mode;
  logic          clr_on_snap, act_high, open_drain, mirror_en;
  logic [NB-1:0] rd_port_stb, rd_snap_stb;
  logic [W-1:0]  port_val, flag_q, snap_q;
  logic [NB-1:0] irq_pin, irq_oe;

  always #10 clk = ~clk;

  gpioic_top #(.PINS_PER_BANK(PPB), .NUM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .dir_is_in(dir_is_in),
    .inv_mask(inv_mask), .watch_en(watch_en), .ref_val(ref_val),
    .ref_mode(ref_mode), .clr_on_snap(clr_on_snap), .act_high(act_high),
    .open_drain(open_drain), .mirror_en(mirror_en), .rd_port_stb(rd_port_stb),
    .rd_snap_stb(rd_snap_stb), .port_val(port_val), .flag_q(flag_q),
    .snap_q(snap_q), .irq_pin(irq_pin), .irq_oe(irq_oe)
  );

  typedef struct {
    string         tag;
    logic [W-1:0]  flag;
    logic [W-1:0]  snap;
    logic [W-1:0]  port;
    logic [NB-1:0] pin;
    logic [NB-1:0] oe;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  task automatic cmp(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the outputs.
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      #1;
      begin
        exp_t it;
        it = sb_q.pop_front();
        cmp(it.tag, "flag", flag_q, it.flag);
        cmp(it.tag, "snap", snap_q, it.snap);
        cmp(it.tag, "port", port_val, it.port);
        cmp(it.tag, "irq_pin", W'(irq_pin), W'(it.pin));
        cmp(it.tag, "irq_oe", W'(irq_oe), W'(it.oe));
      end
    end
  end

  // Driver side: push the expected item, expected port from pins and mask.
  task automatic expect_state(input string tag, input logic [W-1:0] f,
                              input logic [W-1:0] s, input logic [NB-1:0] p,
                              input logic [NB-1:0] o);
    exp_t it;
    it.tag = tag; it.flag = f; it.snap = s; it.port = pin_raw ^ inv_mask;
    it.pin = p; it.oe = o;
    sb_q.push_back(it);
    #2;
  endtask

  task automatic do_reset(input logic [3:0] c, input logic [W-1:0] inv,
                          input logic [W-1:0] en, input logic [W-1:0] dir);
    rst_n = 1'b0;
    pin_raw = '0; inv_mask = inv; dir_is_in = dir; watch_en = '0;
    ref_val = '0; ref_mode = '0; rd_port_stb = '0; rd_snap_stb = '0;
    {mirror_en, open_drain, act_high, clr_on_snap} = c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    watch_en = en;
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    pin_raw = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input bit snap_sel, input int bank);
    @(negedge clk);
    if (snap_sel) rd_snap_stb[bank] = 1'b1; else rd_port_stb[bank] = 1'b1;
    @(negedge clk);
    rd_snap_stb = '0;
    rd_port_stb = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    do_reset(4'b0000, '0, '1, '1);
    expect_state("R1 reset", 16'h0000, 16'h0000, 2'b11, 2'b11);

    // R2: three-edge latency in compare-with-previous mode
    pin_raw = 16'h0008;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_state("R2 not yet", 16'h0000, 16'h0000, 2'b11, 2'b11);
    @(posedge clk);
    @(negedge clk);
    expect_state("R2 fired", 16'h0008, 16'h0008, 2'b10, 2'b11);
    // R4: later pin in same bank adds nothing
    set_pins(16'h0028);
    expect_state("R4 single flag", 16'h0008, 16'h0008, 2'b10, 2'b11);
    // R5: other bank fires, bank0 snapshot untouched
    set_pins(16'h0228);
    expect_state("R5 bank snap", 16'h0208, 16'h0208, 2'b00, 2'b11);
    // R6: snapshot read ignored, port read clears
    pulse(1'b1, 0);
    expect_state("R6 snap read ignored", 16'h0208, 16'h0208, 2'b00, 2'b11);
    pulse(1'b0, 0);
    expect_state("R6 port read clears", 16'h0200, 16'h0208, 2'b01, 2'b11);

    // R7: clear by snapshot read
    do_reset(4'b0001, '0, '1, '1);
    set_pins(16'h0100);
    expect_state("R7 fired", 16'h0100, 16'h0100, 2'b01, 2'b11);
    pulse(1'b0, 1);
    expect_state("R7 port read ignored", 16'h0100, 16'h0100, 2'b01, 2'b11);
    pulse(1'b1, 1);
    expect_state("R7 snap read clears", 16'h0000, 16'h0100, 2'b11, 2'b11);

    // R3 and R8: compare-with-reference, re-raise after clear
    do_reset(4'b0000, '0, '1, '1);
    ref_mode = 16'h1000;
    ref_val  = 16'h1000;
    @(posedge clk);
    @(negedge clk);
    expect_state("R3 mismatch fires", 16'h1000, 16'h0000, 2'b01, 2'b11);
    pulse(1'b0, 1);
    expect_state("R8 cleared", 16'h0000, 16'h0000, 2'b11, 2'b11);
    @(posedge clk);
    @(negedge clk);
    expect_state("R8 re-raised", 16'h1000, 16'h0000, 2'b01, 2'b11);
    set_pins(16'h1000);
    pulse(1'b0, 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_state("R3 match stays quiet", 16'h0000, 16'h0000, 2'b11, 2'b11);

    // R9: enable and direction gating
    do_reset(4'b0000, '0, 16'hFFFE, 16'hFFFD);
    set_pins(16'h0003);
    expect_state("R9 gated pins", 16'h0000, 16'h0000, 2'b11, 2'b11);
    set_pins(16'h0007);
    expect_state("R9 enabled input", 16'h0004, 16'h0007, 2'b10, 2'b11);

    // R10: inversion before compare, capture and port value
    do_reset(4'b0000, 16'h00F0, '1, '1);
    expect_state("R10 port inverted", 16'h0000, 16'h0000, 2'b11, 2'b11);
    set_pins(16'h0010);
    expect_state("R10 inverted capture", 16'h0010, 16'h00E0, 2'b10, 2'b11);

    // R4: lowest index wins on the same edge
    do_reset(4'b0000, '0, '1, '1);
    set_pins(16'h0044);
    expect_state("R4 lowest wins", 16'h0004, 16'h0044, 2'b10, 2'b11);

    // R11: active-high output
    do_reset(4'b0010, '0, '1, '1);
    expect_state("R11 idle high-active", 16'h0000, 16'h0000, 2'b00, 2'b11);
    set_pins(16'h0001);
    expect_state("R11 asserted", 16'h0001, 16'h0001, 2'b01, 2'b11);

    // R12: open drain
    do_reset(4'b0110, '0, '1, '1);
    expect_state("R12 released", 16'h0000, 16'h0000, 2'b00, 2'b00);
    set_pins(16'h0100);
    expect_state("R12 driven", 16'h0100, 16'h0100, 2'b10, 2'b10);

    // R13: mirror
    do_reset(4'b1000, '0, '1, '1);
    set_pins(16'h0002);
    expect_state("R13 mirrored", 16'h0002, 16'h0002, 2'b00, 2'b11);
    pulse(1'b0, 0);
    expect_state("R13 released", 16'h0000, 16'h0002, 2'b11, 2'b11);

    wait (sb_q.size() == 0);
    #5;
    finish_run();
  end
endmodule